// File: doc/BRIEF.md
# Peripheral-to-Memory Block Copy Engine

This engine moves a block of 32-bit words from a peripheral read port into memory with no processor help after setup. The processor writes a destination address, a word count and a transfer mode through a small register port, then issues a start command. From then on the engine requests the shared memory bus from an external arbiter. It takes one word from the peripheral each cycle that it holds the bus and the peripheral has data ready. Each such word is written to memory at an address that rises by four per word.

A run-time mode bit selects how the engine shares the bus. In burst mode it keeps the bus request high from the first word to the last, which gives the shortest block time but locks the processor out of the bus. In cycle-stealing mode it gives the bus back after each group of `STEAL_BEATS` words. The request stays low for exactly one cycle, so the arbiter can serve the processor in between. When the last word is written the engine drops its request, sets a sticky done flag and raises an interrupt for one cycle.

Top module: `dma_engine`

## Requirements
- R1: While rst_ni is low, busy_o, done_o, irq_o, bus_req_o and mem_we_o are 0. After reset, every register reads back as 0.
- R2: reg_sel_i selects a word register: 0 = control (bit0 start, bit1 mode, 1 = burst and 0 = cycle-steal; bit0 reads as 0), 1 = destination address, 2 = word count, 3 = status (bit0 busy, bit1 done). Writing 1 to status bit1 clears done, and writing 0 there leaves it unchanged. Writes to control, destination and count are ignored while busy.
- R3: A start written while idle with a nonzero count makes busy_o and bus_req_o high from the next cycle. bus_req_o is never high while busy_o is low.
- R4: A memory write (mem_we_o) happens only in a cycle where bus_req_o, bus_gnt_i and per_valid_i are all high, and it always happens in such a cycle. per_ready_o equals bus_req_o and bus_gnt_i together. While the peripheral stalls, the destination address holds.
- R5: Each written word carries mem_addr_o equal to the current destination and mem_wdata_o equal to per_data_i. After the write the destination rises by 4 and the count falls by 1.
- R6: In the cycle after the last word is written, busy_o and bus_req_o are 0, done_o is 1 and irq_o is 1. irq_o is high for that one cycle only. done_o then stays set until it is cleared or a new start is accepted.
- R7: In cycle-steal mode, at most STEAL_BEATS words are written per request period. After STEAL_BEATS words, if more remain, bus_req_o goes low for exactly one cycle and then returns high.
- R8: In burst mode, bus_req_o stays high during every busy cycle.
- R9: A start written while busy is ignored. The running transfer continues with its mode, destination sequence and word count unchanged.
- R10: A start with a count of 0 gives done_o = 1 and irq_o = 1 in the next cycle, with no bus request and no memory write.
- R11: With grant and valid held high, a block of n words reaches done n+1 cycles after the start is written in burst mode. In cycle-steal mode it takes n + ceil(n/STEAL_BEATS) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| bus_req_o | output | 1 | Memory bus request to arbiter |
| bus_gnt_i | input | 1 | Memory bus grant from arbiter |
| per_valid_i | input | 1 | Peripheral word available |
| per_data_i | input | 32 | Peripheral word |
| per_ready_o | output | 1 | Engine accepts peripheral word |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach from the ports are register writes that arrive while a transfer runs, together with a grant that is withheld often enough to keep the transfer alive. A second hard case is the one-cycle release window in cycle-steal mode when it coincides with a stalled peripheral. The stimulus uses a slow random grant and a slow valid on a long block, then writes a start with the opposite mode and a new destination mid-flight. It checks that the address sequence, word count and mode readback are undisturbed. Random blocks with random grant and valid rates cover stalls falling inside and outside the steal windows. Directed runs with grant and valid held high pin the exact completion latency in both modes.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_MOVE = 2'd1,
    XS_GAP  = 2'd2
  } xfer_state_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int CTRL_START = 0;
  localparam int CTRL_BURST = 1;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_DONE  = 1;
endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  sel_i,
  input  logic [31:0] wdata_i,
  input  logic        busy_i,
  input  logic        beat_i,
  input  logic        done_set_i,
  output logic [31:0] rdata_o,
  output logic [31:0] dst_o,
  output logic        burst_o,
  output logic        start_o,
  output logic        cnt_zero_o,
  output logic        cnt_last_o,
  output logic        done_o
);
  localparam int PAD_W = 32 - CNT_W;

  logic [31:0]      dst_q;
  logic [CNT_W-1:0] cnt_q;
  logic             burst_q;
  logic             done_q;
  logic             idle_wr;

  assign idle_wr = wr_en_i && !busy_i;
  assign start_o = idle_wr && (sel_i == SEL_CTRL) && wdata_i[CTRL_START];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q   <= '0;
      cnt_q   <= '0;
      burst_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (idle_wr && sel_i == SEL_CTRL) burst_q <= wdata_i[CTRL_BURST];

      if (idle_wr && sel_i == SEL_DST) dst_q <= wdata_i;
      else if (beat_i)                 dst_q <= dst_q + 32'd4;

      if (idle_wr && sel_i == SEL_CNT) cnt_q <= wdata_i[CNT_W-1:0];
      else if (beat_i)                 cnt_q <= cnt_q - CNT_W'(1);

      // set beats clear; accepted start clears stale done
      if (done_set_i)                                         done_q <= 1'b1;
      else if (start_o)                                       done_q <= 1'b0;
      else if (wr_en_i && sel_i == SEL_STAT && wdata_i[STAT_DONE]) done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_CTRL: rdata_o[CTRL_BURST] = burst_q;
      SEL_DST:  rdata_o = dst_q;
      SEL_CNT:  rdata_o = {{PAD_W{1'b0}}, cnt_q};
      default: begin
        rdata_o[STAT_BUSY] = busy_i;
        rdata_o[STAT_DONE] = done_q;
      end
    endcase
  end

  assign dst_o      = dst_q;
  assign burst_o    = burst_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign cnt_last_o = (cnt_q == CNT_W'(1));
  assign done_o     = done_q;
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_pkg::*;
#(
  parameter int STEAL_BEATS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cnt_zero_i,
  input  logic cnt_last_i,
  input  logic burst_i,
  input  logic gnt_i,
  input  logic valid_i,
  output logic busy_o,
  output logic req_o,
  output logic ready_o,
  output logic beat_o,
  output logic done_set_o,
  output logic irq_o
);
  localparam int TW = (STEAL_BEATS > 1) ? $clog2(STEAL_BEATS) : 1;

  xfer_state_e state_q;
  logic        irq_q;
  logic        tenure_end;

  assign req_o      = (state_q == XS_MOVE);
  assign busy_o     = (state_q != XS_IDLE);
  assign ready_o    = req_o && gnt_i;
  assign beat_o     = ready_o && valid_i;
  assign done_set_o = ((state_q == XS_IDLE) && start_i && cnt_zero_i) ||
                      (beat_o && cnt_last_i);

  generate
    if (STEAL_BEATS == 1) begin : g_single
      assign tenure_end = 1'b1;
    end else begin : g_group
      logic [TW-1:0] tcnt_q;
      assign tenure_end = (tcnt_q == TW'(STEAL_BEATS - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  tcnt_q <= '0;
        else if (state_q != XS_MOVE)  tcnt_q <= '0;
        else if (beat_o)              tcnt_q <= tenure_end ? '0 : tcnt_q + TW'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= done_set_o;
      case (state_q)
        XS_IDLE: if (start_i && !cnt_zero_i) state_q <= XS_MOVE;
        XS_MOVE: begin
          if (beat_o) begin
            if (cnt_last_i)                  state_q <= XS_IDLE;
            else if (!burst_i && tenure_end) state_q <= XS_GAP;
          end
        end
        XS_GAP:  state_q <= XS_MOVE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int CNT_W       = 16,
  parameter int STEAL_BEATS = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        bus_req_o,
  input  logic        bus_gnt_i,
  input  logic        per_valid_i,
  input  logic [31:0] per_data_i,
  output logic        per_ready_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        irq_o
);
  logic        busy;
  logic        beat;
  logic        done_set;
  logic        start;
  logic        cnt_zero;
  logic        cnt_last;
  logic        mode_burst;
  logic [31:0] dst;

  dma_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .busy_i     (busy),
    .beat_i     (beat),
    .done_set_i (done_set),
    .rdata_o    (reg_rdata_o),
    .dst_o      (dst),
    .burst_o    (mode_burst),
    .start_o    (start),
    .cnt_zero_o (cnt_zero),
    .cnt_last_o (cnt_last),
    .done_o     (done_o)
  );

  dma_xfer_ctrl #(.STEAL_BEATS(STEAL_BEATS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .cnt_zero_i (cnt_zero),
    .cnt_last_i (cnt_last),
    .burst_i    (mode_burst),
    .gnt_i      (bus_gnt_i),
    .valid_i    (per_valid_i),
    .busy_o     (busy),
    .req_o      (bus_req_o),
    .ready_o    (per_ready_o),
    .beat_o     (beat),
    .done_set_o (done_set),
    .irq_o      (irq_o)
  );

  assign busy_o      = busy;
  assign mem_we_o    = beat;
  assign mem_addr_o  = dst;
  assign mem_wdata_o = per_data_i;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int STEAL_BEATS = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_req_o,
  input logic        bus_gnt_i,
  input logic        per_valid_i,
  input logic        per_ready_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        irq_o,
  input logic        burst_i
);
  logic [15:0] tenure_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tenure_q <= '0;
    else if (!bus_req_o)                  tenure_q <= '0;
    else if (mem_we_o && tenure_q != '1)  tenure_q <= tenure_q + 16'd1;
  end

  assert_write_needs_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (bus_req_o && bus_gnt_i && per_valid_i && per_ready_o));

  assert_stall_holds_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_we_o) |=> $stable(mem_addr_o));

  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (mem_addr_o == $past(mem_addr_o) + 32'd4));

  assert_no_req_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o);

  assert_irq_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);

  assert_done_rise_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> irq_o);

  assert_burst_holds_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && burst_i) |-> bus_req_o);

  assert_steal_tenure_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_i |-> (tenure_q <= 16'(STEAL_BEATS)));

  assert_steal_gap_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bus_req_o) |=> (bus_req_o || !busy_o));
endmodule

bind dma_engine dma_engine_chk #(.STEAL_BEATS(STEAL_BEATS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_o   (bus_req_o),
  .bus_gnt_i   (bus_gnt_i),
  .per_valid_i (per_valid_i),
  .per_ready_o (per_ready_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .irq_o       (irq_o),
  .burst_i     (mode_burst)
);

// File: tb/sim_dma_engine.sv
`timescale 1ns/1ps
module sim_dma_engine;
  localparam int CNT_W = 16;
  localparam int STEAL = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        bus_req_o;
  logic        bus_gnt_i = 1'b0;
  logic        per_valid_i = 1'b0;
  logic [31:0] per_data_i = '0;
  logic        per_ready_o;
  logic        mem_we_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        busy_o;
  logic        done_o;
  logic        irq_o;

  dma_engine #(.CNT_W(CNT_W), .STEAL_BEATS(STEAL)) u0 (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0;
  int fails = 0;
  logic        pend_we = 1'b0;
  logic [1:0]  pend_sel = '0;
  logic [31:0] pend_wdata = '0;
  int          gnt_pct = 100;
  int          val_pct = 100;
  int unsigned data_idx = 0;
  logic [31:0] exp_addr = '0;
  bit          cur_burst = 1'b0;
  int          tenure = 0;
  bit          prev_gap = 1'b0;
  int          beats = 0;
  int          irq_cnt = 0;

  function automatic logic [31:0] word_of(int unsigned i);
    return (i * 32'h9E37_79B9) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    reg_we_i    = pend_we;
    reg_sel_i   = pend_sel;
    reg_wdata_i = pend_wdata;
    pend_we     = 1'b0;
    bus_gnt_i   = bus_req_o && ($urandom_range(99) < gnt_pct);
    per_valid_i = ($urandom_range(99) < val_pct);
    per_data_i  = word_of(data_idx);
    #1;
    if (mem_we_o) begin
      chk(mem_addr_o == exp_addr, "R5 addr", mem_addr_o, exp_addr);
      chk(mem_wdata_o == word_of(data_idx), "R5 data", mem_wdata_o, word_of(data_idx));
      chk(bus_gnt_i && per_valid_i && bus_req_o, "R4 write w/o grant+valid",
          {bus_req_o, bus_gnt_i, per_valid_i}, 32'h7);
      exp_addr += 32'd4;
      data_idx++;
      beats++;
      tenure++;
      if (!cur_burst) chk(tenure <= STEAL, "R7 tenure", tenure, STEAL);
    end else if (bus_req_o && bus_gnt_i && per_valid_i) begin
      chk(1'b0, "R4 missed write", 0, 1);
    end
    if (per_ready_o != (bus_req_o && bus_gnt_i)) chk(1'b0, "R4 ready", per_ready_o, bus_req_o && bus_gnt_i);
    if (!busy_o && bus_req_o) chk(1'b0, "R3 req while idle", 1, 0);
    if (busy_o && !bus_req_o) begin
      if (cur_burst) chk(1'b0, "R8 request dropped", 0, 1);
      else begin
        if (prev_gap) chk(1'b0, "R7 gap longer than one", 2, 1);
        else chk(tenure == STEAL, "R7 release point", tenure, STEAL);
      end
      tenure   = 0;
      prev_gap = 1'b1;
    end else begin
      prev_gap = 1'b0;
    end
    if (irq_o) begin
      irq_cnt++;
      if (!done_o) chk(1'b0, "R6 irq without done", 0, 1);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    pend_we = 1'b1; pend_sel = sel; pend_wdata = d;
    step();
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    pend_sel = sel;
    step();
    d = reg_rdata_o;
  endtask

  task automatic run_xfer(input int n, input bit burst, input logic [31:0] dst,
                          input int gp, input int vp, input bit poke, output int lat);
    logic [31:0] rv;
    bit seen;
    gnt_pct = gp; val_pct = vp;
    wr(2'd1, dst);
    wr(2'd2, 32'(n));
    exp_addr = dst; beats = 0; irq_cnt = 0; tenure = 0; prev_gap = 1'b0;
    cur_burst = burst;
    wr(2'd0, {30'b0, burst, 1'b1});
    lat = 0; seen = 1'b0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      if (poke && k == 3) begin pend_we = 1'b1; pend_sel = 2'd0; pend_wdata = {30'b0, !burst, 1'b1}; end
      if (poke && k == 4) begin pend_we = 1'b1; pend_sel = 2'd1; pend_wdata = 32'hDEAD_0000; end
      if (poke && k == 5) begin pend_we = 1'b1; pend_sel = 2'd2; pend_wdata = 32'd3; end
      if (poke && k == 6) pend_sel = 2'd0;
      step();
      lat++;
      if (k == 0) chk(busy_o && bus_req_o, "R3 start", {busy_o, bus_req_o}, 32'h3);
      if (poke && k == 6) chk(busy_o && reg_rdata_o[1] == burst, "R9 mode kept", reg_rdata_o, {30'b0, burst, 1'b0});
      if (done_o) begin
        seen = 1'b1;
        chk(irq_o, "R6 irq on done", irq_o, 1);
        chk(!busy_o && !bus_req_o, "R6 release", {busy_o, bus_req_o}, 0);
      end
    end
    chk(seen, "R6 completion", seen, 1);
    chk(beats == n, "R5 word count", beats, n);
    step(); step();
    chk(irq_cnt == 1, "R6 single irq", irq_cnt, 1);
    rd(2'd1, rv); chk(rv == dst + 32'(4 * n), "R5 final dst", rv, dst + 32'(4 * n));
    rd(2'd2, rv); chk(rv == 0, "R5 count drained", rv, 0);
    rd(2'd3, rv); chk(rv == 32'h2, "R2 status done", rv, 32'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int lat_b, lat_s, lat;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk_i);
    #1;
    chk(!busy_o && !done_o && !irq_o && !bus_req_o && !mem_we_o, "R1 reset outputs",
        {busy_o, done_o, irq_o, bus_req_o, mem_we_o}, 0);
    rst_ni = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), rv);
      chk(rv == 0, "R1 reset register", rv, 0);
    end

    // exact latency, both modes
    run_xfer(6, 1'b1, 32'h1000_0000, 100, 100, 1'b0, lat_b);
    chk(lat_b == 7, "R11 burst latency", lat_b, 7);
    run_xfer(6, 1'b0, 32'h2000_0000, 100, 100, 1'b0, lat_s);
    chk(lat_s == 9, "R11 steal latency", lat_s, 9);
    chk(lat_b < lat_s, "R11 burst faster", lat_b, lat_s);
    run_xfer(5, 1'b0, 32'h2100_0000, 100, 100, 1'b0, lat);
    chk(lat == 8, "R11 steal odd latency", lat, 8);

    // writes during a running transfer are ignored
    run_xfer(20, 1'b0, 32'h3000_0040, 30, 50, 1'b1, lat);
    run_xfer(20, 1'b1, 32'h3100_0000, 100, 40, 1'b1, lat);

    // done write-one-to-clear
    wr(2'd3, 32'h1);
    rd(2'd3, rv); chk(rv[1] == 1'b1, "R2 done not cleared by 0", rv, 32'h2);
    wr(2'd3, 32'h2);
    rd(2'd3, rv); chk(rv[1] == 1'b0 && !done_o, "R2 done cleared by 1", rv, 0);

    // zero count
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h1);
    step();
    chk(done_o && irq_o && !busy_o && !bus_req_o, "R10 zero count",
        {done_o, irq_o, busy_o, bus_req_o}, 32'hC);
    step();
    chk(!irq_o && !bus_req_o && !mem_we_o, "R10 no access", {irq_o, bus_req_o, mem_we_o}, 0);

    // random blocks
    for (int i = 0; i < 30; i++) begin
      run_xfer($urandom_range(1, 12), 1'($urandom_range(1)), $urandom() & 32'hFFFF_FFFC,
               $urandom_range(30, 100), $urandom_range(30, 100), 1'b0, lat);
    end

    // reset in flight
    gnt_pct = 50; val_pct = 50;
    cur_burst = 1'b0; tenure = 0; prev_gap = 1'b0;
    wr(2'd1, 32'h4000_0000); exp_addr = 32'h4000_0000;
    wr(2'd2, 32'd30);
    wr(2'd0, 32'h1);
    repeat (6) step();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(!busy_o && !bus_req_o && !done_o && !irq_o, "R1 reset mid transfer",
        {busy_o, bus_req_o, done_o, irq_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(2'd2, rv); chk(rv == 0, "R1 count cleared", rv, 0);
    rd(2'd1, rv); chk(rv == 0, "R1 dst cleared", rv, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule